// File: doc/BRIEF.md
# Clocked Serial Byte Transfer Channel

This block moves one byte at a time over a three-wire synchronous serial link. It shifts the transmit byte out on a serial data output and captures a byte from the serial data input over the same eight clock cycles. It can run as master or as slave.

As master it generates the serial clock itself. The clock comes either from a power-of-two division of the system clock or from an external baud tick. As slave it takes the serial clock from the clock pin, through a synchronizer. A small control register selects the clock source, the idle level of the clock and the data phase.

Software starts a transfer by writing the transmit byte while the channel is idle. It learns of completion from a one-cycle done pulse that carries the received byte. A chip that needs two channels places two instances, and each has its own control register.

Top module: `csi_channel`

## Requirements
- R1: After reset the control register reads 0x00. It reads back as {3'b000, pol, pha, csel[2:0]}, so bit 4 is polarity, bit 3 is phase, bits 2..0 are clock select, and bits 7..5 always read 0.
- R2: With csel 0..5 the channel is master, and each half period of the serial clock lasts HALF_MAX >> csel system cycles (64, 32, 16, 8, 4 and 2 with the default HALF_MAX of 64).
- R3: With csel 6 the channel is master, and each pulse of `brg_tick` advances the serial clock by one half period.
- R4: With csel 7 the channel is slave: `sck_oe` is 0, and the clock on `sck_in` passes through a two-flop synchronizer before its edges are detected.
- R5: In master mode `sck_oe` is 1. Between transfers `sck_out` rests high when pol is 0 and low when pol is 1.
- R6: With pha 0, the MSB appears on `sdo` in the cycle after the start. Data is sampled on each leading clock edge (the edge away from the idle level) and changes on each trailing edge.
- R7: With pha 1, `sdo` keeps its previous value until the first leading edge. Data changes on leading edges and is sampled on trailing edges.
- R8: A transfer moves exactly 8 bits, MSB first, over 16 clock edges. The received byte holds the captured bits with the first captured bit in bit 7.
- R9: A `tx_we` while idle starts a transfer, and `busy` is 1 from the next cycle. On the final edge `done` pulses for exactly one cycle, `rx_data` presents the byte and `busy` clears in that same cycle.
- R10: A control write or a transmit write while `busy` is 1 has no effect: the control readback and the byte in flight are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| ctl_rdata | output | 8 | Control register readback |
| tx_we | input | 1 | Transmit byte write; starts a transfer when idle |
| tx_data | input | NBITS | Byte to send |
| rx_data | output | NBITS | Byte received by the last transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| brg_tick | input | 1 | External baud tick, one half period per pulse |
| sck_in | input | 1 | Serial clock from the pin (slave) |
| sck_out | output | 1 | Serial clock to the pin (master) |
| sck_oe | output | 1 | Serial clock pin drive enable |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |

## Verification
The bench uses the default HALF_MAX of 64 and NBITS of 8. With these values all six divisors can be measured exactly, from 64 cycles per half period down to 2, and a full transfer at the slowest divisor stays near a thousand cycles. A free-running baud tick every third cycle gives the external-clock source a half period that no divisor produces, so selecting the wrong source shows up. With the data output looped back to the input, every combination of polarity and phase is run as master and as slave.

// File: rtl/csi_channel.sv
module csi_channel #(
  parameter int NBITS    = 8,
  parameter int HALF_MAX = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  output logic [7:0]       ctl_rdata,
  input  logic             tx_we,
  input  logic [NBITS-1:0] tx_data,
  output logic [NBITS-1:0] rx_data,
  output logic             busy,
  output logic             done,
  input  logic             brg_tick,
  input  logic             sck_in,
  output logic             sck_out,
  output logic             sck_oe,
  input  logic             sdi,
  output logic             sdo
);
  localparam int PW = $clog2(HALF_MAX);
  localparam int EW = $clog2(2 * NBITS);
  localparam logic [EW-1:0] LAST_EDGE = EW'(2 * NBITS - 1);

  logic             pol, pha;
  logic [2:0]       csel;
  logic [PW-1:0]    pre;
  logic [EW-1:0]    ecnt;
  logic             lvl, sdo_q;
  logic             s1, s2, s3;
  logic [NBITS-1:0] tsr, rsr;

  wire unused_ok = &{1'b0, ctl_wdata[7:5]};

  wire          slave   = (csel == 3'd7);
  wire          use_brg = (csel == 3'd6);
  wire [PW:0]   half    = (PW+1)'(HALF_MAX) >> csel;
  wire [PW:0]   half_m1 = half - 1'b1;
  wire          tick    = use_brg ? brg_tick : ({1'b0, pre} == half_m1);
  wire          s_edge  = s2 ^ s3;
  wire          edge_ev = busy & (slave ? s_edge : tick);
  wire          lead    = ~ecnt[0];
  wire          smp     = edge_ev & (pha ? ~lead : lead);
  wire          shf     = edge_ev & (pha ? lead : ~lead);
  wire          last    = edge_ev & (ecnt == LAST_EDGE);
  wire          start   = tx_we & ~busy;
  wire [NBITS-1:0] rsr_n = smp ? {rsr[NBITS-2:0], sdi} : rsr;

  assign ctl_rdata = {3'b000, pol, pha, csel};
  assign sck_out   = lvl ^ ~pol;
  assign sck_oe    = ~slave;
  assign sdo       = sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol <= 1'b0; pha <= 1'b0; csel <= 3'd0;
      pre <= '0; ecnt <= '0; lvl <= 1'b0; sdo_q <= 1'b0;
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
      tsr <= '0; rsr <= '0; rx_data <= '0;
      busy <= 1'b0; done <= 1'b0;
    end else begin
      s1 <= sck_in; s2 <= s1; s3 <= s2;
      done <= 1'b0;
      if (ctl_we && !busy) {pol, pha, csel} <= ctl_wdata[4:0];
      if (start) begin
        busy <= 1'b1;
        ecnt <= '0;
        lvl  <= 1'b0;
        pre  <= '0;
        rsr  <= '0;
        if (pha) tsr <= tx_data;
        else begin
          tsr   <= {tx_data[NBITS-2:0], 1'b0};
          sdo_q <= tx_data[NBITS-1];
        end
      end else if (busy) begin
        pre <= tick ? '0 : pre + 1'b1;
        rsr <= rsr_n;
        if (shf) begin
          sdo_q <= tsr[NBITS-1];
          tsr   <= {tsr[NBITS-2:0], 1'b0};
        end
        if (edge_ev) begin
          ecnt <= ecnt + 1'b1;
          lvl  <= ~lvl;
        end
        if (last) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_data <= rsr_n;
          lvl     <= 1'b0;
        end
      end
    end
  end

  a_r10_ctl_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_we) |=> $stable(ctl_rdata));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_we && !busy) |=> busy);
  a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !slave) |-> (sck_out == ~pol));
  a_r6_msb_first_out: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_we && !busy && !pha && !ctl_we) |=> (sdo == $past(tx_data[NBITS-1])));
endmodule

// File: tb/csi_channel_tb.sv
module csi_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SL_HALF    = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 1'b0, tx_we = 1'b0, brg_tick, sck_in = 1'b1;
  logic [7:0] ctl_wdata = '0, tx_data = '0;
  logic [7:0] ctl_rdata, rx_data;
  logic busy, done, sck_out, sck_oe, sdo, sdi;
  logic [1:0] bcnt;
  logic [7:0] exp_q[$];
  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdi = sdo;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0; else bcnt <= (bcnt == 2'd2) ? 2'd0 : bcnt + 2'd1;
  assign brg_tick = (bcnt == 2'd2);

  csi_channel u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .tx_we(tx_we), .tx_data(tx_data), .rx_data(rx_data),
    .busy(busy), .done(done), .brg_tick(brg_tick), .sck_in(sck_in),
    .sck_out(sck_out), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected done", 1, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        chk(rx_data == e, "R8 received byte", rx_data, e);
      end
    end
  end

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic start_tx(input logic [7:0] d);
    exp_q.push_back(d);
    @(negedge clk); tx_we = 1'b1; tx_data = d;
    @(negedge clk); tx_we = 1'b0;
  endtask

  task automatic xfer_m(input logic [7:0] ctl, input logic [7:0] d);
    int half = (ctl[2:0] == 3'd6) ? 3 : (64 >> ctl[2:0]);
    logic p = ctl[4], ph = ctl[3], prev, last_sck;
    logic [7:0] cap = '0;
    int cyc = 0, last_t = 0, nedge = 0, badp = 0;
    wr_ctl(ctl);
    chk(sck_oe == 1'b1, "R5 master drives clock", sck_oe, 1);
    chk(sck_out == ~p, "R5 idle level", sck_out, ~p);
    prev = sdo;
    start_tx(d);
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    if (ph) chk(sdo == prev, "R7 output held before first edge", sdo, prev);
    else    chk(sdo == d[7], "R6 MSB presented at start", sdo, d[7]);
    last_sck = sck_out;
    while (cyc < 5000) begin
      if (sck_out != last_sck) begin
        nedge++;
        if (nedge > 1 && (cyc - last_t) != half) badp = cyc - last_t;
        last_t = cyc;
        if (ph ? (sck_out != p) : (sck_out == p)) cap = {cap[6:0], sdo};
        last_sck = sck_out;
      end
      if (done) break;
      @(negedge clk); cyc++;
    end
    chk(done == 1'b1 && busy == 1'b0, "R9 done with busy cleared", {done, busy}, 2);
    chk(nedge == 16, "R8 sixteen clock edges", nedge, 16);
    if (ctl[2:0] == 3'd6) chk(badp == 0, "R3 baud tick half period", badp, half);
    else                  chk(badp == 0, "R2 divided half period", badp, half);
    chk(cap == d, ph ? "R7 bits on trailing edges" : "R6 bits on leading edges", cap, d);
    @(negedge clk);
    chk(done == 1'b0, "R9 done lasts one cycle", done, 0);
    chk(sck_out == ~p, "R5 clock back at idle", sck_out, ~p);
  endtask

  task automatic xfer_s(input logic [7:0] ctl, input logic [7:0] d);
    logic p = ctl[4], ph = ctl[3];
    logic [7:0] cap = '0;
    int g = 0;
    sck_in = ~p;
    wr_ctl(ctl);
    repeat (5) @(negedge clk);
    chk(sck_oe == 1'b0, "R4 slave releases clock", sck_oe, 0);
    start_tx(d);
    for (int i = 0; i < 16; i++) begin
      repeat (SL_HALF) @(negedge clk);
      if (ph ? (i % 2 == 1) : (i % 2 == 0)) cap = {cap[6:0], sdo};
      sck_in = ~sck_in;
    end
    while (!done && g < 40) begin @(negedge clk); g++; end
    chk(done == 1'b1, "R4 slave transfer completes", done, 1);
    chk(cap == d, "R8 slave MSB first", cap, d);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctl_rdata == 8'h00, "R1 reset value", ctl_rdata, 0);
    chk(busy == 1'b0 && done == 1'b0, "R9 idle after reset", {busy, done}, 0);
    chk(sck_oe == 1'b1 && sck_out == 1'b1, "R5 reset clock high", {sck_oe, sck_out}, 3);
    wr_ctl(8'hFF);
    chk(ctl_rdata == 8'h1F, "R1 upper bits read zero", ctl_rdata, 8'h1F);
    chk(sck_oe == 1'b0, "R4 slave select", sck_oe, 0);
    wr_ctl(8'h10);
    chk(sck_out == 1'b0, "R5 polarity 1 idles low", sck_out, 0);

    xfer_m(8'h00, 8'hA5);
    xfer_m(8'h09, 8'h3C);
    xfer_m(8'h12, 8'h96);
    xfer_m(8'h1B, 8'h5A);
    xfer_m(8'h04, 8'hC1);
    xfer_m(8'h0D, 8'h7E);
    xfer_m(8'h16, 8'h81);
    xfer_m(8'h0E, 8'h2D);

    xfer_s(8'h07, 8'hB4);
    xfer_s(8'h0F, 8'h69);
    xfer_s(8'h17, 8'hE2);
    xfer_s(8'h1F, 8'h1D);

    wr_ctl(8'h05);
    start_tx(8'hC3);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = 8'h1A; tx_we = 1'b1; tx_data = 8'h00;
    @(negedge clk); ctl_we = 1'b0; tx_we = 1'b0;
    chk(ctl_rdata == 8'h05, "R10 control write ignored", ctl_rdata, 8'h05);
    begin
      int g = 0;
      while (!done && g < 200) begin @(negedge clk); g++; end
    end
    chk(done == 1'b1 && rx_data == 8'hC3, "R10 byte in flight kept", rx_data, 8'hC3);
    @(negedge clk);
    chk(exp_q.size() == 0, "R9 every transfer completed", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule